// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block gathers up to 32 interrupt request inputs from peripherals and hands a single interrupt line to a processor. Each request is latched into a status bit, qualified by a per-line enable, and the lowest-numbered qualified line is offered to software as a vector number. Software manages the controller through eight 32-bit word registers on a plain read/write bus. Enable bits can be set or cleared individually without a read-modify-write sequence. Serviced lines are acknowledged by writing ones. A two-bit master register gates request capture and the processor output.

Each line is built as either edge-sensitive or level-sensitive through a bit mask parameter, and software cannot change that choice. A level line refills its status bit on every cycle that its input is high. As a result, an acknowledge only takes effect once the source has dropped its request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A bus write to byte offset 16 sets every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R2: A bus write to byte offset 20 clears every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R3: A bus write to byte offset 12 clears the status bits (read at offset 0) whose data bit is one. Writing all ones clears every status bit whose line is not capturing in that same cycle.
- R4: Offset 4 reads the pending set, equal to status AND enable. Writes to offsets 0, 4 and 24 change no state.
- R5: Offset 24 reads the index of the lowest-numbered pending line, where line 0 has the highest priority. It reads 0xFFFFFFFF when no line is pending.
- R6: The CPU interrupt output is high exactly when master bit 0 is one and at least one pending bit is one.
- R7: An edge line sets its status bit only in the cycle after its input goes from 0 to 1. An acknowledged edge line stays clear while its input is held high.
- R8: A level line sets its status bit in every cycle in which its input is high. An acknowledge of that line therefore has no lasting effect until the input is low.
- R9: Requests are captured into status only while master bit 1 is one. While it is zero, status changes only through acknowledge.
- R10: When a line captures a request in the same cycle as an acknowledge of that line, the status bit ends up set.
- R11: After reset, status, enable and master are zero, offset 24 reads 0xFFFFFFFF, and the CPU interrupt output is low.
- R12: Offset 8 reads and writes the enable register directly. Offset 28 holds the two master bits (bit 0 gates the output, bit 1 gates capture), and its upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Interrupt request inputs, bit n is line n |
| bus_en | input | 1 | Bus access strobe, a write happens when bus_we is also high |
| bus_we | input | 1 | Write select |
| bus_addr | input | ADDR_W | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
Request capture and acknowledge both write the status register, and they can fall in the same clock edge. The bench raises an edge line on the same edge that carries an acknowledge write for that line. It then reads status back and expects the bit to remain set. It also holds a level line high through an acknowledge and expects the bit to survive. Finally, it sweeps every enable pattern over a fully set status under three master settings, and checks pending, vector and the output against values worked out in the bench.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;

   localparam int REG_W = 32;

   // Word index of each register (byte offset divided by four)
   typedef enum logic [2:0] {
      W_STATUS = 3'd0,
      W_PEND   = 3'd1,
      W_ENABLE = 3'd2,
      W_ACK    = 3'd3,
      W_SETEN  = 3'd4,
      W_CLREN  = 3'd5,
      W_VECTOR = 3'd6,
      W_MASTER = 3'd7
   } word_e;

   localparam logic [REG_W-1:0] NO_VECTOR = '1;

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
   parameter int                   NUM_LINES = 32,
   parameter logic [NUM_LINES-1:0] EDGE_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [NUM_LINES-1:0] ack_mask,
   output logic [NUM_LINES-1:0] status
);

   logic [NUM_LINES-1:0] prev_q;
   logic [NUM_LINES-1:0] hit;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (EDGE_MASK[i]) begin : g_edge
         assign hit[i] = irq_in[i] & ~prev_q[i];
      end else begin : g_level
         assign hit[i] = irq_in[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= irq_in;
         status <= (status & ~ack_mask) | (hit & {NUM_LINES{arm}});
      end
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_LINES = 32,
   parameter int VEC_W     = 5
) (
   input  logic [NUM_LINES-1:0] req,
   output logic                 valid,
   output logic [VEC_W-1:0]     idx
);

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (req[i]) begin
            valid = 1'b1;
            idx   = VEC_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_vc_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int VEC_W     = 5,
   parameter int ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   input  logic [NUM_LINES-1:0] status,
   input  logic [NUM_LINES-1:0] pending,
   input  logic                 vec_valid,
   input  logic [VEC_W-1:0]     vec_idx,
   output logic [NUM_LINES-1:0] enable,
   output logic [1:0]           master,
   output logic [NUM_LINES-1:0] ack_mask,
   output logic                 wr_ack,
   output logic [REG_W-1:0]     bus_rdata
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0]    word;
   logic                 wr;
   logic [NUM_LINES-1:0] wmask;

   assign word  = bus_addr[ADDR_W-1:2];
   assign wr    = bus_en & bus_we;
   assign wmask = bus_wdata[NUM_LINES-1:0];

   function automatic logic hit_word(input logic [WORD_W-1:0] w, input word_e r);
      return w == WORD_W'(r);
   endfunction

   assign wr_ack   = wr & hit_word(word, W_ACK);
   assign ack_mask = wr_ack ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= '0;
         master <= '0;
      end else if (wr) begin
         if (hit_word(word, W_ENABLE)) enable <= wmask;
         if (hit_word(word, W_SETEN))  enable <= enable | wmask;
         if (hit_word(word, W_CLREN))  enable <= enable & ~wmask;
         if (hit_word(word, W_MASTER)) master <= bus_wdata[1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_word(word, W_STATUS)) bus_rdata = REG_W'(status);
      if (hit_word(word, W_PEND))   bus_rdata = REG_W'(pending);
      if (hit_word(word, W_ENABLE)) bus_rdata = REG_W'(enable);
      if (hit_word(word, W_VECTOR)) bus_rdata = vec_valid ? REG_W'(vec_idx) : NO_VECTOR;
      if (hit_word(word, W_MASTER)) bus_rdata = REG_W'(master);
   end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vc_pkg::*;
#(
   parameter int                   NUM_LINES = 32,
   parameter logic [NUM_LINES-1:0] EDGE_MASK = '1,
   parameter int                   ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 cpu_irq
);

   localparam int VEC_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_lines
      $error("NUM_LINES must lie between 1 and 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5 to reach all eight registers");
   end

   logic [NUM_LINES-1:0] status;
   logic [NUM_LINES-1:0] enable;
   logic [NUM_LINES-1:0] pending;
   logic [NUM_LINES-1:0] ack_mask;
   logic [1:0]           master;
   logic                 wr_ack;
   logic                 vec_valid;
   logic [VEC_W-1:0]     vec_idx;

   assign pending = status & enable;
   assign cpu_irq = master[0] & (|pending);

   irq_capture #(
      .NUM_LINES (NUM_LINES),
      .EDGE_MASK (EDGE_MASK)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (master[1]),
      .irq_in   (irq_in),
      .ack_mask (ack_mask),
      .status   (status)
   );

   irq_prio_enc #(
      .NUM_LINES (NUM_LINES),
      .VEC_W     (VEC_W)
   ) u_enc (
      .req   (pending),
      .valid (vec_valid),
      .idx   (vec_idx)
   );

   irq_regfile #(
      .NUM_LINES (NUM_LINES),
      .VEC_W     (VEC_W),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .status    (status),
      .pending   (pending),
      .vec_valid (vec_valid),
      .vec_idx   (vec_idx),
      .enable    (enable),
      .master    (master),
      .ack_mask  (ack_mask),
      .wr_ack    (wr_ack),
      .bus_rdata (bus_rdata)
   );

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int                   NUM_LINES = 32,
   parameter logic [NUM_LINES-1:0] EDGE_MASK = '1,
   parameter int                   ADDR_W    = 5,
   parameter int                   VEC_W     = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_in,
   input logic                 bus_en,
   input logic                 bus_we,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [31:0]          bus_wdata,
   input logic                 cpu_irq,
   input logic [NUM_LINES-1:0] status,
   input logic [NUM_LINES-1:0] enable,
   input logic [1:0]           master,
   input logic                 wr_ack,
   input logic                 vec_valid,
   input logic [VEC_W-1:0]     vec_idx
);

   localparam logic [NUM_LINES-1:0] LEVEL_MASK = ~EDGE_MASK;

   logic wr_set, wr_clr;
   assign wr_set = bus_en && bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4));
   assign wr_clr = bus_en && bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(5));

   assert_set_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((enable & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

   assert_clear_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((enable & $past(bus_wdata[NUM_LINES-1:0])) == '0));

   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !master[1]) |=> ((status & $past(bus_wdata[NUM_LINES-1:0])) == '0));

   assert_vector_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (int'(vec_idx) < NUM_LINES));

   assert_output_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == (master[0] && vec_valid));

   assert_level_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      master[1] |=> ((status & $past(irq_in) & LEVEL_MASK) == ($past(irq_in) & LEVEL_MASK)));

   assert_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!master[1] && !wr_ack) |=> $stable(status));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .NUM_LINES (NUM_LINES),
   .EDGE_MASK (EDGE_MASK),
   .ADDR_W    (ADDR_W),
   .VEC_W     (VEC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_in    (irq_in),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .cpu_irq   (cpu_irq),
   .status    (status),
   .enable    (enable),
   .master    (master),
   .wr_ack    (wr_ack),
   .vec_valid (vec_valid),
   .vec_idx   (vec_idx)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

   localparam int           CLK_PERIOD = 10;
   localparam int           NL         = 8;
   localparam logic [NL-1:0] EDGES     = 8'h0F;
   localparam int           AW         = 5;

   localparam logic [4:0] A_STATUS = 5'd0,  A_PEND  = 5'd4,  A_EN    = 5'd8,
                          A_ACK    = 5'd12, A_SET   = 5'd16, A_CLR   = 5'd20,
                          A_VEC    = 5'd24, A_MAST  = 5'd28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_in = '0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          cpu_irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_ctrl #(.NUM_LINES(NL), .EDGE_MASK(EDGES), .ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cpu_irq   (cpu_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   function automatic logic [31:0] lowest(input logic [NL-1:0] p);
      for (int i = 0; i < NL; i++) if (p[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rchk("R11 status", A_STATUS, 32'h0);
      rchk("R11 enable", A_EN, 32'h0);
      rchk("R11 master", A_MAST, 32'h0);
      rchk("R11 vector", A_VEC, 32'hFFFF_FFFF);
      chk("R11 cpu_irq", 32'(cpu_irq), 32'h0);

      // R9 no capture while master bit 1 is zero
      @(negedge clk); irq_in = 8'h21;
      repeat (3) @(negedge clk); irq_in = 8'h00;
      @(negedge clk);
      rchk("R9 status held", A_STATUS, 32'h0);

      // R12 direct enable and master access
      wr(A_EN, 32'h0000_005A);
      rchk("R12 enable direct", A_EN, 32'h5A);
      wr(A_MAST, 32'hFFFF_FFFF);
      rchk("R12 master two bits", A_MAST, 32'h3);

      // R1 / R2 atomic set and clear
      wr(A_SET, 32'h81);
      rchk("R1 set-enable", A_EN, 32'hDB);
      wr(A_CLR, 32'h1A);
      rchk("R2 clear-enable", A_EN, 32'hC1);

      // R4 read-only registers
      wr(A_STATUS, 32'hFF); wr(A_PEND, 32'hFF); wr(A_VEC, 32'h3);
      rchk("R4 status ignores write", A_STATUS, 32'h0);
      rchk("R4 pending ignores write", A_PEND, 32'h0);
      rchk("R4 vector ignores write", A_VEC, 32'hFFFF_FFFF);

      // R7 edge line 2
      wr(A_SET, 32'hFF);
      @(negedge clk); irq_in[2] = 1'b1;
      @(negedge clk);
      rchk("R7 edge captured", A_STATUS, 32'h04);
      rchk("R5 vector line 2", A_VEC, 32'h2);
      chk("R6 cpu_irq high", 32'(cpu_irq), 32'h1);
      wr(A_ACK, 32'h04);
      repeat (3) @(negedge clk);
      rchk("R7 held high stays clear", A_STATUS, 32'h0);
      chk("R6 cpu_irq low", 32'(cpu_irq), 32'h0);
      irq_in[2] = 1'b0;
      @(negedge clk);
      rchk("R7 falling edge ignored", A_STATUS, 32'h0);

      // R8 level line 6
      irq_in[6] = 1'b1;
      @(negedge clk);
      rchk("R8 level captured", A_STATUS, 32'h40);
      wr(A_ACK, 32'h40);
      rchk("R8 ack while high", A_STATUS, 32'h40);
      irq_in[6] = 1'b0;
      @(negedge clk);
      rchk("R8 latched after drop", A_STATUS, 32'h40);
      wr(A_ACK, 32'h40);
      rchk("R8 ack after drop", A_STATUS, 32'h0);

      // R10 capture and acknowledge on the same edge
      @(negedge clk);
      irq_in[1] = 1'b1;
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h02;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      rchk("R10 capture wins", A_STATUS, 32'h02);
      irq_in[1] = 1'b0;

      // R3 partial and full acknowledge
      @(negedge clk); irq_in[0] = 1'b1; irq_in[3] = 1'b1;
      @(negedge clk); irq_in[0] = 1'b0; irq_in[3] = 1'b0;
      @(negedge clk);
      rchk("R3 three set", A_STATUS, 32'h0B);
      wr(A_ACK, 32'h02);
      rchk("R3 partial ack", A_STATUS, 32'h09);
      rchk("R5 vector line 0", A_VEC, 32'h0);
      wr(A_ACK, 32'hFFFF_FFFF);
      rchk("R3 full ack", A_STATUS, 32'h0);

      // fill every status bit
      @(negedge clk); irq_in = 8'hFF;
      @(negedge clk); irq_in = 8'hF0;
      @(negedge clk);
      rchk("R8 all set", A_STATUS, 32'hFF);

      // R4/R5/R6 sweep of all enable patterns under three master values
      for (int m = 1; m <= 3; m++) begin
         wr(A_MAST, 32'(m));
         for (int p = 0; p < 256; p++) begin
            wr(A_EN, 32'(p));
            rchk("R4 pending sweep", A_PEND, 32'(p));
            rchk("R5 vector sweep", A_VEC, lowest(8'(p)));
            chk("R6 cpu_irq sweep", 32'(cpu_irq), 32'(((m & 1) != 0) && (p != 0)));
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule